// File: doc/BRIEF.md
# Prescaled Interval Timer

This block produces a periodic interrupt for the rest of the chip. A 16-bit count steps down by one each time an 8-bit prescale divider runs out. When a step finds the count at its terminal value, the block gives a one-cycle interrupt pulse. In the same edge it reloads the count from a 16-bit period register, and counting goes on at once with no idle cycle. Software sets the period and the divider ratio, and can seed the count directly. All of this goes through a single-word register write port with a two-bit address.

The enable input freezes all timing state while it is low. Register writes are still accepted while the timer is frozen. The current count is brought out so that the owner of the timer can watch its progress.

Top module: `interval_timer`

## Requirements
- R1: While reset is high at a clock edge, the count, the period, the prescale value and the divider state are all cleared, and the interrupt is low in the cycle after that edge.
- R2: With prescale value S and enable held high, the count changes once every S+1 clock cycles. After a direct count write, the first step comes S+1 enabled cycles later. S=255 gives a step every 256 cycles.
- R3: A step taken while the count is 2 or more lowers the count by exactly one.
- R4: A step taken while the count is 0 or 1 loads the count from the period register. In the same edge, the interrupt goes high for exactly one cycle.
- R5: After a reload, the next step follows S+1 enabled cycles later, the same spacing as any other step.
- R6: A write to address 0 loads the count from the write data and restarts the divider from the current prescale value. No step and no interrupt occur for that edge.
- R7: A write to address 1 sets the period and leaves the running count and divider untouched. The new period is used at the next reload.
- R8: A write to address 2 sets the prescale value from the low 8 data bits. The divider run already in progress keeps its old length, and the new value applies from the next divider reload. The count is not changed.
- R9: While enable is low, the count and divider hold their state and the interrupt stays low. A direct count write still takes effect.
- R10: With a period of 0 or 1, every step reloads and pulses the interrupt, so the interrupt fires once per S+1 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes the divider and count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write address: 0 count, 1 period, 2 prescale, 3 unused |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current count value |
| irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
Directed runs first separate the divider ratios. A ratio of 2 shows when the first step lands after a seed write. A ratio of 255 exposes an off-by-one divider at its widest setting. A period of 0 with ratio 0 shows whether back-to-back reloads keep pulsing. Enable is dropped in the middle of a run, which tells a true freeze apart from a divider that keeps running underneath. Random mixes of enable gaps, writes to all four addresses and small periods and ratios then probe writes that collide with steps and reloads. A cycle-by-cycle bench model tells a lost reload apart from an extra decrement.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    parameter int CNT_BITS   = 16;
    parameter int SCALE_BITS = 8;
    localparam int SEL_BITS  = 2;

    typedef enum logic [SEL_BITS-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_SPARE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic ld_count;
        logic ld_period;
        logic ld_scale;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic strobe,
                                             input logic [SEL_BITS-1:0] sel);
        wr_dec_t d;
        d.ld_count  = strobe && (sel == SEL_COUNT);
        d.ld_period = strobe && (sel == SEL_PERIOD);
        d.ld_scale  = strobe && (sel == SEL_SCALE);
        return d;
    endfunction

endpackage

// File: rtl/itmr_cfg_regs.sv
module itmr_cfg_regs #(
    parameter int CNT_W = itmr_pkg::CNT_BITS,
    parameter int PS_W  = itmr_pkg::SCALE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  itmr_pkg::wr_dec_t dec,
    input  logic [CNT_W-1:0] period_d,
    input  logic [PS_W-1:0]  scale_d,
    output logic [CNT_W-1:0] period_q,
    output logic [PS_W-1:0]  scale_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            if (dec.ld_period) period_q <= period_d;
            if (dec.ld_scale)  scale_q  <= scale_d;
        end
    end
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
    parameter int PS_W = itmr_pkg::SCALE_BITS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            restart,
    input  logic [PS_W-1:0] scale,
    output logic            tick
);
    logic [PS_W-1:0] remain;

    always_comb tick = en && !restart && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (restart) begin
            remain <= scale;
        end else if (en) begin
            if (remain == '0) remain <= scale;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/itmr_down_counter.sv
module itmr_down_counter #(
    parameter int CNT_W = itmr_pkg::CNT_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic terminal;
    always_comb terminal = (count <= LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                count <= load_val;
            end else if (tick) begin
                if (terminal) begin
                    count <= period;
                    irq   <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = itmr_pkg::CNT_BITS,
    parameter int PS_W  = itmr_pkg::SCALE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    itmr_pkg::wr_dec_t dec;
    logic [CNT_W-1:0]  period_q;
    logic [PS_W-1:0]   scale_q;
    logic              tick;

    always_comb dec = itmr_pkg::decode_write(wr_en, wr_sel);

    itmr_cfg_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cfg (
        .clk(clk), .rst(rst), .dec(dec),
        .period_d(wr_data), .scale_d(wr_data[PS_W-1:0]),
        .period_q(period_q), .scale_q(scale_q)
    );

    itmr_prescaler #(.PS_W(PS_W)) u_div (
        .clk(clk), .rst(rst), .en(en), .restart(dec.ld_count),
        .scale(scale_q), .tick(tick)
    );

    itmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(dec.ld_count),
        .load_val(wr_data), .period(period_q), .count(count), .irq(irq)
    );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             tick,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] count,
    input logic             irq
);
    logic cnt_wr;
    always_comb cnt_wr = wr_en && (wr_sel == 2'd0);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == '0) && !irq); // R1
    AST_NO_STEP_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(count)); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count > CNT_W'(1)) |=> (count == $past(count) - 1'b1) && !irq); // R3
    AST_RELOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && count <= CNT_W'(1)) |=> irq && (count == $past(period))); // R4
    AST_SEED_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count == $past(wr_data)) && !irq); // R6
    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en && !cnt_wr) |=> $stable(count) && !irq); // R9
endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .period(period_q), .count(count), .irq(irq)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    // bench model of the timer state
    logic [15:0] m_cnt = '0, m_per = '0;
    logic [7:0]  m_ps = '0, m_pc = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    interval_timer u_interval_timer (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count(count), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_next(input bit r, input bit e, input bit we,
                                       input logic [1:0] sel, input logic [15:0] d);
        logic [15:0] c_n = m_cnt, p_n = m_per;
        logic [7:0]  s_n = m_ps, pc_n = m_pc;
        logic        i_n = 1'b0;
        bit ldc = we && sel == 2'd0;
        bit tk  = e && !ldc && m_pc == 8'd0;
        if (r) begin
            m_cnt = '0; m_per = '0; m_ps = '0; m_pc = '0; m_irq = 1'b0;
            return;
        end
        if (ldc) pc_n = m_ps;
        else if (e) pc_n = (m_pc == 8'd0) ? m_ps : m_pc - 8'd1;
        if (ldc) c_n = d;
        else if (tk) begin
            if (m_cnt <= 16'd1) begin c_n = m_per; i_n = 1'b1; end
            else c_n = m_cnt - 16'd1;
        end
        if (we && sel == 2'd1) p_n = d;
        if (we && sel == 2'd2) s_n = d[7:0];
        m_cnt = c_n; m_per = p_n; m_ps = s_n; m_pc = pc_n; m_irq = i_n;
    endfunction

    // one clock: drive, advance model, sample after the edge
    task automatic step(input bit e, input bit we, input logic [1:0] sel, input logic [15:0] d);
        en = e; wr_en = we; wr_sel = sel; wr_data = d;
        model_next(rst, e, we, sel, d);
        @(posedge clk); #1;
        cycles++;
        check(count == m_cnt, "R3 count vs model", count, m_cnt);
        check(irq == m_irq, "R4 irq vs model", irq, m_irq);
    endtask

    task automatic idle(input int n, input bit e);
        for (int i = 0; i < n; i++) step(e, 1'b0, 2'd3, 16'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        idle(3, 1'b0);
        rst = 1'b0;
        check(count == 0 && irq == 0, "R1 reset state", count, 0);

        step(1'b0, 1'b1, 2'd1, 16'd4);
        step(1'b0, 1'b1, 2'd2, 16'h0302);
        check(count == 0, "R7 period write leaves count", count, 0);
        check(count == 0, "R8 prescale write leaves count", count, 0);
        step(1'b0, 1'b1, 2'd0, 16'd3);
        check(count == 3, "R6 seed write", count, 3);

        idle(2, 1'b1);
        check(count == 3, "R2 no step before S+1 cycles", count, 3);
        idle(1, 1'b1);
        check(count == 2, "R3 first step after S+1", count, 2);
        idle(3, 1'b1);
        check(count == 1, "R3 second step", count, 1);
        idle(3, 1'b1);
        check(count == 4 && irq == 1, "R4 reload with pulse", count, 4);
        idle(1, 1'b1);
        check(irq == 0, "R4 pulse lasts one cycle", irq, 0);
        idle(2, 1'b1);
        check(count == 3, "R5 no idle cycle after reload", count, 3);

        idle(10, 1'b0);
        check(count == 3 && irq == 0, "R9 frozen while disabled", count, 3);
        step(1'b0, 1'b1, 2'd0, 16'd9);
        check(count == 9, "R9 seed write while disabled", count, 9);

        step(1'b1, 1'b1, 2'd2, 16'd255);
        check(count == 9, "R8 new prescale not on running count", count, 9);
        step(1'b1, 1'b1, 2'd0, 16'd2);
        idle(255, 1'b1);
        check(count == 2, "R2 ratio 255 holds for 255 cycles", count, 2);
        idle(1, 1'b1);
        check(count == 1, "R2 ratio 255 steps on cycle 256", count, 1);

        step(1'b1, 1'b1, 2'd1, 16'd0);
        step(1'b1, 1'b1, 2'd2, 16'd0);
        step(1'b1, 1'b1, 2'd0, 16'd1);
        check(irq == 0, "R6 no pulse on seed edge", irq, 0);
        idle(1, 1'b1);
        check(count == 0 && irq == 1, "R10 period zero reload", count, 0);
        idle(1, 1'b1);
        check(count == 0 && irq == 1, "R10 pulse every step", irq, 1);

        for (int i = 0; i < 3000; i++) begin
            bit e  = ($urandom % 5) != 0;
            bit we = ($urandom % 12) == 0;
            logic [1:0] sel = 2'($urandom % 4);
            logic [15:0] d = (sel == 2'd2) ? 16'($urandom % 4) : 16'($urandom % 7);
            step(e, we, sel, d);
        end

        rst = 1'b1;
        idle(1, 1'b1);
        rst = 1'b0;
        check(count == 0 && irq == 0, "R1 reset mid-run", count, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule